// File: doc/BRIEF.md
# PCM Sample Streamer

This block plays back a run of 8-bit audio samples held in memory. Software sets a start address, a run length and an enable bit through three write registers. While enabled, a period counter counts CPU cycles. Each time a period expires, the block either fetches one byte over a simple memory request/valid port and sends its upper seven bits to a DAC register, or ends the run. When the run ends, it raises an interrupt flag.

The period is 246 (0xF6) CPU cycles. A CPU cycle is marked by the `cpu_tick` input, so the block can sit on a faster clock. While a fetch is outstanding, the period counter waits. The interrupt flag appears both on the `irq` pin and as the top bit of a status word. The other status bits come from outside and pass through unchanged. A step is the moment a period expires and the length register is decremented.

Top module: `pcm_sample_streamer`

## Requirements
- R1: A write with `wr_sel`=0 loads the sample address with `wr_data` shifted left by 6; the next fetch presents that address on `mem_addr`.
- R2: A write with `wr_sel`=1 loads a signed 16-bit length with (`wr_data` << 4) + 1. Each step decrements the length. A run started with length L delivers exactly L bytes before it ends.
- R3: A write with `wr_sel`=2 sets the enable from `wr_data` bit 4. A write with bit 4 set also reloads the period counter to 246, so the first step falls on the 246th counted tick.
- R4: The period counter only moves on cycles with `cpu_tick` high while the block is enabled and no fetch is outstanding. A step occurs each time the counter reaches zero, and 246 is then added back.
- R5: A step that leaves the length at zero or above issues a fetch. The cycle after `mem_valid` is accepted, `dac_strobe` pulses with `dac_data` equal to the fetched byte shifted right by one.
- R6: After each delivered byte, the sample address increments and wraps within 15 bits (0x7FFF wraps to 0).
- R7: A step that drives the length below zero sets the interrupt flag and clears the enable, and issues no fetch. `irq` follows the flag.
- R8: Any control write clears the interrupt flag. A control write with bit 4 clear stops the run and discards any outstanding fetch, so its data never reaches the DAC.
- R9: `status_out` bit 7 carries the interrupt flag; bits 6..0 copy `status_in`.
- R10: `mem_req` is a one-cycle pulse, and at most one fetch is outstanding at a time.
- R11: After reset the block is disabled with the interrupt flag clear, and `mem_req` and `dac_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 length, 2 control |
| wr_data | input | 8 | Register write data |
| cpu_tick | input | 1 | One CPU cycle has elapsed |
| status_in | input | 7 | Other status bits, passed through |
| status_out | output | 8 | Status word, bit 7 is the interrupt flag |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Fetch request pulse |
| mem_addr | output | 15 | Fetch address |
| mem_valid | input | 1 | Fetch data valid |
| mem_data | input | 8 | Fetch data |
| dac_strobe | output | 1 | DAC write pulse |
| dac_data | output | 7 | DAC sample value |

## Verification
The hardest case to reach is a control write that clears the enable while a fetch is still outstanding, followed by the stale `mem_valid` arriving after the run has stopped. The bench stretches its memory latency to 30 cycles, waits until it sees `mem_req`, and then issues the disabling write. It then checks that no DAC strobe follows and that a later re-enable resumes with the length already reduced by the cancelled step. Address wrap needs thousands of bytes at the default size, so a second instance with a 7-bit address and a short period covers the wrap within a few hundred cycles.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int ENABLE_BIT = 4;

endpackage

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
    parameter int PERIOD = 246,
    parameter int CNT_W  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic hold,
    input  logic run,
    input  logic tick,
    output logic step
);
    localparam logic signed [CNT_W-1:0] PERIOD_S = CNT_W'(PERIOD);

    typedef struct packed {
        logic signed [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;
    logic signed [CNT_W-1:0] dec_d;

    always_comb begin
        s_d   = s_q;
        step  = 1'b0;
        dec_d = s_q.cnt - CNT_W'(1);
        if (reload) begin
            s_d.cnt = PERIOD_S;
        end else if (run && tick && !hold) begin
            if (dec_d[CNT_W-1] || (dec_d == '0)) begin
                s_d.cnt = dec_d + PERIOD_S;
                step    = 1'b1;
            end else begin
                s_d.cnt = dec_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= PERIOD_S;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pcm_run_ctrl.sv
module pcm_run_ctrl #(
    parameter int LEN_W     = 16,
    parameter int DATA_W    = 8,
    parameter int LEN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_wr,
    input  logic              ctrl_wr,
    input  logic              ctrl_en_bit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output logic              en,
    output logic              irq_flag,
    output logic              fetch_go
);
    typedef struct packed {
        logic signed [LEN_W-1:0] len;
        logic                    en;
        logic                    irq;
    } run_s;

    run_s s_d, s_q;
    logic signed [LEN_W-1:0] nlen_d;

    always_comb begin
        s_d      = s_q;
        fetch_go = 1'b0;
        nlen_d   = s_q.len - LEN_W'(1);
        if (step) begin
            s_d.len = nlen_d;
            if (nlen_d[LEN_W-1]) begin
                s_d.irq = 1'b1;
                s_d.en  = 1'b0;
            end else begin
                fetch_go = 1'b1;
            end
        end
        if (len_wr) begin
            s_d.len = (LEN_W'(wr_data) << LEN_SHIFT) + LEN_W'(1);
        end
        if (ctrl_wr) begin
            s_d.en  = ctrl_en_bit;
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.len <= '0;
            s_q.en  <= 1'b0;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en       = s_q.en;
    assign irq_flag = s_q.irq;

endmodule

// File: rtl/pcm_fetch_unit.sv
module pcm_fetch_unit #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int DAC_W      = 7,
    parameter int ADDR_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fetch_go,
    input  logic              cancel,
    input  logic              mem_valid,
    input  logic [DAC_W-1:0]  mem_hi,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              dac_strobe,
    output logic [DAC_W-1:0]  dac_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              busy;
        logic              req;
        logic              strobe;
        logic [DAC_W-1:0]  dac;
    } fetch_s;

    fetch_s s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.req    = 1'b0;
        s_d.strobe = 1'b0;
        if (s_q.busy && mem_valid && !cancel) begin
            s_d.strobe = 1'b1;
            s_d.dac    = mem_hi;
            s_d.addr   = s_q.addr + ADDR_W'(1);
            s_d.busy   = 1'b0;
        end
        if (fetch_go) begin
            s_d.req  = 1'b1;
            s_d.busy = 1'b1;
        end
        if (cancel) begin
            s_d.req  = 1'b0;
            s_d.busy = 1'b0;
        end
        if (addr_wr) begin
            s_d.addr = ADDR_W'(ADDR_W'(wr_data) << ADDR_SHIFT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.addr   <= '0;
            s_q.busy   <= 1'b0;
            s_q.req    <= 1'b0;
            s_q.strobe <= 1'b0;
            s_q.dac    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req    = s_q.req;
    assign mem_addr   = s_q.addr;
    assign busy       = s_q.busy;
    assign dac_strobe = s_q.strobe;
    assign dac_data   = s_q.dac;

endmodule

// File: rtl/pcm_sample_streamer.sv
module pcm_sample_streamer #(
    parameter int PERIOD     = 246,
    parameter int ADDR_W     = 15,
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 8,
    parameter int ADDR_SHIFT = 6,
    parameter int LEN_SHIFT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_tick,
    input  logic [DATA_W-2:0] status_in,
    output logic [DATA_W-1:0] status_out,
    output logic              irq,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic              dac_strobe,
    output logic [DATA_W-2:0] dac_data
);
    import pcm_dma_pkg::*;

    localparam int DAC_W = DATA_W - 1;
    localparam int CNT_W = $clog2(PERIOD + 1) + 2;

    reg_sel_e sel;
    logic     addr_wr, len_wr, ctrl_wr, en_bit;
    logic     en, busy, step, fetch_go, irq_flag;
    logic     data_lsb_unused;

    assign sel     = reg_sel_e'(wr_sel);
    assign addr_wr = wr_en && (sel == SEL_ADDR);
    assign len_wr  = wr_en && (sel == SEL_LEN);
    assign ctrl_wr = wr_en && (sel == SEL_CTRL);
    assign en_bit  = wr_data[ENABLE_BIT];
    assign data_lsb_unused = mem_data[0];

    pcm_period_timer #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (ctrl_wr && en_bit),
        .hold   (ctrl_wr),
        .run    (en && !busy),
        .tick   (cpu_tick),
        .step   (step)
    );

    pcm_run_ctrl #(
        .LEN_W     (LEN_W),
        .DATA_W    (DATA_W),
        .LEN_SHIFT (LEN_SHIFT)
    ) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_wr      (len_wr),
        .ctrl_wr     (ctrl_wr),
        .ctrl_en_bit (en_bit),
        .wr_data     (wr_data),
        .step        (step),
        .en          (en),
        .irq_flag    (irq_flag),
        .fetch_go    (fetch_go)
    );

    pcm_fetch_unit #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .DAC_W      (DAC_W),
        .ADDR_SHIFT (ADDR_SHIFT)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wr    (addr_wr),
        .wr_data    (wr_data),
        .fetch_go   (fetch_go),
        .cancel     (ctrl_wr && !en_bit),
        .mem_valid  (mem_valid),
        .mem_hi     (mem_data[DATA_W-1:1]),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .dac_strobe (dac_strobe),
        .dac_data   (dac_data)
    );

    assign irq        = irq_flag;
    assign status_out = {irq_flag, status_in};

endmodule

// File: rtl/pcm_sample_streamer_chk.sv
module pcm_sample_streamer_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              irq,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              dac_strobe
);
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_strobe_follows_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |-> $past(mem_valid));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_strobe && !$past(wr_en && (wr_sel == 2'd0)))
        |-> (mem_addr == ($past(mem_addr) + ADDR_W'(1))));

    p_ctrl_clears_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd2)) |=> !irq);

    p_no_fetch_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !mem_req);

    p_req_not_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !irq);

endmodule

bind pcm_sample_streamer pcm_sample_streamer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .irq        (irq),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .dac_strobe (dac_strobe)
);

// File: tb/pcm_sample_streamer_tb_top.sv
`timescale 1ns/1ps
module pcm_sample_streamer_tb_top;

    localparam int PER = 246;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       cpu_tick = 1'b0;
    logic [6:0] status_in = 7'h5A;
    logic [7:0] status_out;
    logic       irq, mem_req, mem_valid = 1'b0, dac_strobe;
    logic [14:0] mem_addr;
    logic [7:0] mem_data = 8'h00;
    logic [6:0] dac_data;

    logic       w_wr_en = 1'b0;
    logic [1:0] w_wr_sel = 2'd3;
    logic [7:0] w_wr_data = 8'h00;
    logic [7:0] w_status_out;
    logic       w_irq, w_mem_req, w_mem_valid = 1'b0, w_dac_strobe;
    logic [6:0] w_mem_addr;
    logic [7:0] w_mem_data = 8'h00;
    logic [6:0] w_dac_data;

    always #5 clk = ~clk;

    pcm_sample_streamer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cpu_tick(cpu_tick), .status_in(status_in), .status_out(status_out), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .dac_strobe(dac_strobe), .dac_data(dac_data)
    );

    pcm_sample_streamer #(.PERIOD(4), .ADDR_W(7)) dut_w (
        .clk(clk), .rst_n(rst_n), .wr_en(w_wr_en), .wr_sel(w_wr_sel), .wr_data(w_wr_data),
        .cpu_tick(1'b1), .status_in(7'h00), .status_out(w_status_out), .irq(w_irq),
        .mem_req(w_mem_req), .mem_addr(w_mem_addr), .mem_valid(w_mem_valid), .mem_data(w_mem_data),
        .dac_strobe(w_dac_strobe), .dac_data(w_dac_data)
    );

    int n_checks = 0;
    int n_fail = 0;

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a * 37) + 11);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // tick pattern: 0 every cycle, 1 every other cycle, 2 never
    int tick_mode = 0;
    int tick_cyc = 0;
    always @(negedge clk) begin
        tick_cyc++;
        cpu_tick = (tick_mode == 0) || ((tick_mode == 1) && tick_cyc[0]);
    end

    // memory for dut_i with settable latency
    int lat = 2;
    int mem_wait = -1;
    int pend_addr = 0;
    always @(negedge clk) begin
        mem_valid = 1'b0;
        if (mem_wait == 0) begin
            mem_valid = 1'b1;
            mem_data  = mem_byte(pend_addr);
            mem_wait  = -1;
        end else if (mem_wait > 0) begin
            mem_wait--;
        end
        if (mem_req) begin
            pend_addr = int'(mem_addr);
            mem_wait  = lat;
        end
    end

    // memory for dut_w, answers on the next cycle
    bit w_pend = 1'b0;
    int w_pend_addr = 0;
    always @(negedge clk) begin
        w_mem_valid = w_pend;
        w_mem_data  = mem_byte(w_pend_addr);
        w_pend = w_mem_req;
        if (w_mem_req) w_pend_addr = int'(w_mem_addr);
    end

    // monitors
    int n_strobe = 0, n_req = 0, first_req_addr = -1;
    int w_nreq = 0, w_strobe = 0, w_addr64 = -1, w_addr65 = -1;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (dac_strobe) n_strobe++;
            if (mem_req) begin
                n_req++;
                if (first_req_addr < 0) first_req_addr = int'(mem_addr);
            end
            if (w_dac_strobe) w_strobe++;
            if (w_mem_req) begin
                w_nreq++;
                if (w_nreq == 64) w_addr64 = int'(w_mem_addr);
                if (w_nreq == 65) w_addr65 = int'(w_mem_addr);
            end
        end
    end

    // behavioural reference model for dut_i
    int m_en, m_busy, m_cnt, m_len, m_addr, m_irq, m_req, m_strobe, m_dac;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_cnt = PER; m_len = 0; m_addr = 0;
            m_irq = 0; m_req = 0; m_strobe = 0; m_dac = 0;
        end else begin
            bit ctrl, b4, cancel, stp, was_busy;
            ctrl = wr_en && (wr_sel == 2'd2);
            b4 = wr_data[4];
            cancel = ctrl && !b4;
            was_busy = (m_busy != 0);
            stp = 0;
            m_req = 0;
            m_strobe = 0;
            if (ctrl && b4) m_cnt = PER;
            else if (m_en != 0 && !was_busy && cpu_tick && !ctrl) begin
                m_cnt = m_cnt - 1;
                if (m_cnt <= 0) begin
                    m_cnt = m_cnt + PER;
                    stp = 1;
                end
            end
            if (was_busy && mem_valid && !cancel) begin
                m_strobe = 1;
                m_dac = int'(mem_data) / 2;
                m_addr = (m_addr + 1) % 32768;
                m_busy = 0;
            end
            if (stp) begin
                m_len = m_len - 1;
                if (m_len < 0) begin
                    m_irq = 1;
                    m_en = 0;
                end else begin
                    m_req = 1;
                    m_busy = 1;
                end
            end
            if (wr_en && wr_sel == 2'd0) m_addr = int'(wr_data) * 64;
            if (wr_en && wr_sel == 2'd1) m_len = int'(wr_data) * 16 + 1;
            if (ctrl) begin
                m_en = b4;
                m_irq = 0;
                if (!b4) begin
                    m_busy = 0;
                    m_req = 0;
                end
            end
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            check(irq == m_irq[0], "R7 irq vs model", int'(irq), m_irq);
            check(mem_req == m_req[0], "R3/R4/R10 mem_req vs model", int'(mem_req), m_req);
            if (m_req != 0)
                check(int'(mem_addr) == m_addr, "R1/R6 mem_addr vs model", int'(mem_addr), m_addr);
            check(dac_strobe == m_strobe[0], "R5 dac_strobe vs model", int'(dac_strobe), m_strobe);
            if (m_strobe != 0)
                check(int'(dac_data) == m_dac, "R5 dac_data vs model", int'(dac_data), m_dac);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic w_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        w_wr_en = 1'b1; w_wr_sel = s; w_wr_data = d;
        @(negedge clk);
        w_wr_en = 1'b0; w_wr_sel = 2'd3;
    endtask

    task automatic set_tick(int m);
        @(posedge clk);
        tick_mode = m;
    endtask

    task automatic set_lat(int l);
        @(posedge clk);
        lat = l;
    endtask

    task automatic wait_irq(int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int s0;
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11 / R9 reset state
        @(negedge clk);
        check(irq == 1'b0, "R11 irq after reset", int'(irq), 0);
        check(mem_req == 1'b0 && dac_strobe == 1'b0, "R11 req/strobe after reset",
              int'({mem_req, dac_strobe}), 0);
        check(status_out == 8'h5A, "R9 status after reset", int'(status_out), 'h5A);

        // single-byte run: R1 R2 R3 R5 R7 R9
        set_tick(0);
        set_lat(2);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h10);
        wait_irq(2000);
        check(first_req_addr == 'h140, "R1 first fetch address", first_req_addr, 'h140);
        check(n_strobe == 1, "R2 bytes for length write 0", n_strobe, 1);
        check(irq == 1'b1, "R7 irq at run end", int'(irq), 1);
        #1;
        check(status_out == 8'hDA, "R9 status with irq", int'(status_out), 'hDA);

        // R8 control write clears irq
        wr(2'd2, 8'h00);
        check(irq == 1'b0, "R8 irq cleared by control write", int'(irq), 0);

        // R4 no ticks -> no fetch
        set_tick(2);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h01);
        r0 = n_req;
        wr(2'd2, 8'h10);
        repeat (600) @(negedge clk);
        check(n_req == r0, "R4 no fetch without ticks", n_req, r0);

        // R2 R4 alternate ticks, longer latency, 17 bytes
        s0 = n_strobe;
        set_lat(5);
        set_tick(1);
        wait_irq(20000);
        check(n_strobe - s0 == 17, "R2 bytes for length write 1", n_strobe - s0, 17);
        check(irq == 1'b1, "R7 irq after 17 bytes", int'(irq), 1);
        wr(2'd2, 8'h00);

        // R8 cancel outstanding fetch, then resume
        set_tick(0);
        set_lat(30);
        wr(2'd1, 8'h02);
        wr(2'd2, 8'h10);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (mem_req) break;
        end
        s0 = n_strobe;
        wr(2'd2, 8'h00);
        repeat (60) @(negedge clk);
        check(n_strobe == s0, "R8 cancelled fetch not delivered", n_strobe - s0, 0);
        check(irq == 1'b0, "R8 no irq after stop", int'(irq), 0);
        set_lat(1);
        wr(2'd2, 8'h10);
        wait_irq(20000);
        check(n_strobe - s0 == 32, "R8 remaining bytes after resume", n_strobe - s0, 32);

        // R6 wrap on the narrow instance
        w_wr(2'd0, 8'h01);
        w_wr(2'd1, 8'h04);
        w_wr(2'd2, 8'h10);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (w_irq) break;
        end
        check(w_addr64 == 'h7F, "R6 address before wrap", w_addr64, 'h7F);
        check(w_addr65 == 0, "R6 address wraps to zero", w_addr65, 0);
        check(w_strobe == 65, "R2 narrow instance byte count", w_strobe, 65);
        check(w_irq == 1'b1, "R7 narrow instance irq", int'(w_irq), 1);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule